// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds the configuration registers of a system controller in a 4 KB window of 32-bit words. Software reaches it through a simple register bus: one request per cycle with a write flag, a byte address and write data, answered one cycle later with read data and an error flag. The clock, PLL and pin-mux registers only store values. Nothing in the block acts on them.

Writes to the protected registers are gated by a software lock. The lock opens when an exact 16-bit unlock key is written to a dedicated key register, and it closes when a different exact key is written to a second one. Every word offset has a fixed access class: read-write, read-only, write-only or unmapped. Any access that breaks its class raises the error flag and is dropped.

Setting bit 0 of the reset-control register while the lock is open raises a one-cycle system reset request.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the lock is closed and the lock-status word (byte offset 0x00C) reads 1. Reset values are 0x0001A008 for PLL control (0x100), 0x3F for PLL status (0x10C), 0x40 for reset reason (0x250), 0x1 for boot mode (0x25C) and 0x1601 for every pin-mux word (from 0x700). The reset request output is low.
- R2: A write to the unlock key word (0x008) whose low 16 bits equal 0xDF0D opens the lock, whatever the upper 16 bits hold. Lock status then reads 0.
- R3: A write to the lock key word (0x004) whose low 16 bits equal 0x767B closes the lock. Any other value written to either key word leaves the lock state unchanged.
- R4: While the lock is closed, a write to a protected read-write register is dropped without error, and that register keeps its value.
- R5: The word at offset 0 stores only bit 0 of the written data and accepts writes whether the lock is open or closed.
- R6: The key words and the two DDR start words (0x60C and 0x614) are write-only. A read of any of them returns 0 with the error flag set. A write to a DDR start word is accepted without error.
- R7: A write to a read-only word (lock status, PLL status, boot mode, ID code at 0x530) sets the error flag and leaves the read value unchanged.
- R8: A read of an unmapped offset returns 0 with the error flag set. A write to an unmapped offset sets the error flag and changes no state.
- R9: A write to reset control (0x200) with bit 0 set, while the lock is open, pulses the reset request for exactly one cycle, on the cycle after the request. The register stores the full written value. The same write while the lock is closed raises no pulse.
- R10: Each request is answered by a response valid for exactly one cycle, one cycle later, with no response in idle cycles. The low two address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, 0 for writes and failed reads |
| rsp_err | output | 1 | Access broke the offset's class |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle the assertions check four things. Responses follow requests by exactly one cycle. Error responses carry zero data. An unmapped access is always flagged. Every lock transition and every reset pulse is traced back to the exact key write or the unlocked reset-control write that caused it.

Only the bench scenarios can show the effects that need a read after a write. These include the stored values surviving a locked write, masking to one bit at offset 0, and rejection of near-miss keys. They also cover the absence of a reset pulse while locked and aliasing through the ignored low address bits.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int          NUM_RSTCTL = 4,
  parameter int          NUM_PINMUX = 16,
  parameter logic [31:0] ID_VALUE   = 32'h0372_3093,
  parameter logic [31:0] BOOT_VALUE = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        sys_rst_req
);
  localparam int NUM_PLL = 3;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;
  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [31:0] PLL_STAT_VALUE = 32'h0000_003F;

  localparam int W_CTRL0    = 'h000;
  localparam int W_LOCK     = 'h001;
  localparam int W_UNLOCK   = 'h002;
  localparam int W_LSTAT    = 'h003;
  localparam int W_PLL_CTRL = 'h040;
  localparam int W_PLL_STAT = 'h043;
  localparam int W_PLL_CFG  = 'h044;
  localparam int W_RST_CTL  = 'h080;
  localparam int W_RST_RSN  = 'h094;
  localparam int W_BOOT     = 'h097;
  localparam int W_ID       = 'h14C;
  localparam int W_DDR_CAL  = 'h183;
  localparam int W_DDR_REF  = 'h185;
  localparam int W_PINMUX   = 'h1C0;

  localparam int S_PLLC  = 0;
  localparam int S_PLLG  = S_PLLC + NUM_PLL;
  localparam int S_RST   = S_PLLG + NUM_PLL;
  localparam int S_RSN   = S_RST + NUM_RSTCTL;
  localparam int S_PIN   = S_RSN + 1;
  localparam int NUM_RW  = S_PIN + NUM_PINMUX;
  localparam int SLOT_W  = $clog2(NUM_RW);

  typedef enum logic [1:0] {C_NONE, C_RO, C_WO, C_RW} acc_class_e;

  function automatic logic [31:0] reset_value(int s);
    if (s < S_PLLG)     return 32'h0001_A008;
    else if (s < S_RST) return 32'h0001_4000;
    else if (s < S_RSN) return 32'h0000_0000;
    else if (s == S_RSN) return 32'h0000_0040;
    else                return 32'h0000_1601;
  endfunction

  logic [31:0] rw_q [NUM_RW];
  logic        ctrl0_q;
  logic        locked_q;

  int          widx;
  acc_class_e  cls;
  logic        in_slot;
  logic [SLOT_W-1:0] slot;
  logic [31:0] rd_val;
  logic        bad;
  logic        wr_ok;

  assign widx = int'(req_addr[11:2]);

  always_comb begin
    cls     = C_NONE;
    in_slot = 1'b0;
    slot    = '0;
    if (widx == W_CTRL0)
      cls = C_RW;
    else if (widx == W_LOCK || widx == W_UNLOCK || widx == W_DDR_CAL || widx == W_DDR_REF)
      cls = C_WO;
    else if (widx == W_LSTAT || widx == W_PLL_STAT || widx == W_BOOT || widx == W_ID)
      cls = C_RO;
    else if (widx >= W_PLL_CTRL && widx < W_PLL_CTRL + NUM_PLL) begin
      cls = C_RW; in_slot = 1'b1; slot = SLOT_W'(widx - W_PLL_CTRL + S_PLLC);
    end else if (widx >= W_PLL_CFG && widx < W_PLL_CFG + NUM_PLL) begin
      cls = C_RW; in_slot = 1'b1; slot = SLOT_W'(widx - W_PLL_CFG + S_PLLG);
    end else if (widx >= W_RST_CTL && widx < W_RST_CTL + NUM_RSTCTL) begin
      cls = C_RW; in_slot = 1'b1; slot = SLOT_W'(widx - W_RST_CTL + S_RST);
    end else if (widx == W_RST_RSN) begin
      cls = C_RW; in_slot = 1'b1; slot = SLOT_W'(S_RSN);
    end else if (widx >= W_PINMUX && widx < W_PINMUX + NUM_PINMUX) begin
      cls = C_RW; in_slot = 1'b1; slot = SLOT_W'(widx - W_PINMUX + S_PIN);
    end
  end

  always_comb begin
    rd_val = '0;
    if (widx == W_CTRL0)         rd_val = {31'b0, ctrl0_q};
    else if (widx == W_LSTAT)    rd_val = {31'b0, locked_q};
    else if (widx == W_PLL_STAT) rd_val = PLL_STAT_VALUE;
    else if (widx == W_BOOT)     rd_val = BOOT_VALUE;
    else if (widx == W_ID)       rd_val = ID_VALUE;
    else if (in_slot)            rd_val = rw_q[slot];
  end

  assign bad   = req_write ? (cls == C_NONE || cls == C_RO)
                           : (cls == C_NONE || cls == C_WO);
  assign wr_ok = req_valid && req_write && in_slot && !locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RW; i++) rw_q[i] <= reset_value(i);
    end else if (wr_ok) begin
      rw_q[slot] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0_q  <= 1'b0;
      locked_q <= 1'b1;
    end else if (req_valid && req_write) begin
      if (widx == W_CTRL0)
        ctrl0_q <= req_wdata[0];
      if (widx == W_UNLOCK && req_wdata[15:0] == KEY_OPEN)
        locked_q <= 1'b0;
      if (widx == W_LOCK && req_wdata[15:0] == KEY_CLOSE)
        locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_err     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_err     <= req_valid && bad;
      rsp_rdata   <= (req_valid && !req_write && !bad) ? rd_val : '0;
      sys_rst_req <= wr_ok && widx == W_RST_CTL && req_wdata[0];
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        sys_rst_req,
  input logic        locked
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0)); // R6
  AST_UNMAPPED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:2] == 10'h3FF) |=> rsp_err); // R8
  AST_OPEN_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(req_valid && req_write && req_addr[11:2] == 10'h002
                            && req_wdata[15:0] == 16'hDF0D)); // R2
  AST_CLOSE_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(req_valid && req_write && req_addr[11:2] == 10'h001
                            && req_wdata[15:0] == 16'h767B)); // R3
  AST_RST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(req_valid && req_write && req_addr[11:2] == 10'h080
                          && req_wdata[0] && !locked)); // R9
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sys_rst_req(sys_rst_req),
  .locked(locked_q)
);

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_d[$];
  logic        exp_e[$];
  string       exp_t[$];

  always #10 clk = ~clk;

  sysctl_regs dut (.*);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_d.size() == 0) begin
        check(1'b0, "R10 unexpected response", 32'h1, 32'h0);
      end else begin
        logic [31:0] d;
        logic        e;
        string       t;
        d = exp_d.pop_front();
        e = exp_e.pop_front();
        t = exp_t.pop_front();
        check(rsp_rdata == d, {t, " data"}, rsp_rdata, d);
        check(rsp_err == e, {t, " err"}, {31'b0, rsp_err}, {31'b0, e});
      end
    end
  end

  task automatic xfer(logic wr, logic [11:0] a, logic [31:0] d,
                      logic [31:0] ed, logic ee, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_d.push_back(ed); exp_e.push_back(ee); exp_t.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic ee, string tag);
    xfer(1'b1, a, d, 32'h0, ee, tag);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] ed, logic ee, string tag);
    xfer(1'b0, a, 32'h0, ed, ee, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check(sys_rst_req == 1'b0, "R1 reset request low", {31'b0, sys_rst_req}, 32'h0);
    check(rsp_valid == 1'b0, "R1 no response", {31'b0, rsp_valid}, 32'h0);
    rd(12'h00C, 32'h1, 1'b0, "R1 lock status");
    rd(12'h10C, 32'h3F, 1'b0, "R1 pll status");
    rd(12'h25C, 32'h1, 1'b0, "R1 boot mode");
    rd(12'h250, 32'h40, 1'b0, "R1 reset reason");
    rd(12'h700, 32'h1601, 1'b0, "R1 pinmux");
    rd(12'h100, 32'h0001A008, 1'b0, "R1 pll ctrl");

    wr(12'h100, 32'h1234, 1'b0, "R4 locked write");
    rd(12'h100, 32'h0001A008, 1'b0, "R4 value kept");
    wr(12'h200, 32'h1, 1'b0, "R9 locked reset write");
    check(sys_rst_req == 1'b0, "R9 no pulse locked", {31'b0, sys_rst_req}, 32'h0);
    rd(12'h200, 32'h0, 1'b0, "R9 locked reset ctl kept");

    wr(12'h000, 32'hFFFF_FFFF, 1'b0, "R5 write while locked");
    rd(12'h000, 32'h1, 1'b0, "R5 bit0 only");
    wr(12'h000, 32'h2, 1'b0, "R5 write bit1");
    rd(12'h000, 32'h0, 1'b0, "R5 cleared");

    wr(12'h008, 32'h0000_DF0E, 1'b0, "R3 wrong unlock key");
    rd(12'h00C, 32'h1, 1'b0, "R3 still locked");
    wr(12'h008, 32'hABCD_DF0D, 1'b0, "R2 unlock");
    rd(12'h00C, 32'h0, 1'b0, "R2 unlocked");

    wr(12'h100, 32'h1234_5678, 1'b0, "R2 write unlocked");
    rd(12'h100, 32'h1234_5678, 1'b0, "R2 readback");
    wr(12'h704, 32'hA5, 1'b0, "R10 pinmux write");
    rd(12'h707, 32'hA5, 1'b0, "R10 low bits ignored");

    wr(12'h10C, 32'h0, 1'b1, "R7 write read-only");
    rd(12'h10C, 32'h3F, 1'b0, "R7 value kept");
    wr(12'h00C, 32'h1, 1'b1, "R7 write lock status");
    rd(12'h00C, 32'h0, 1'b0, "R7 lock status kept");

    rd(12'h004, 32'h0, 1'b1, "R6 read lock key");
    rd(12'h60C, 32'h0, 1'b1, "R6 read ddr start");
    wr(12'h614, 32'h1, 1'b0, "R6 write ddr start");

    rd(12'h800, 32'h0, 1'b1, "R8 unmapped read");
    wr(12'hFFC, 32'h5, 1'b1, "R8 unmapped write");
    rd(12'hFFC, 32'h0, 1'b1, "R8 unmapped read again");

    wr(12'h200, 32'h3, 1'b0, "R9 reset write");
    check(sys_rst_req == 1'b1, "R9 pulse high", {31'b0, sys_rst_req}, 32'h1);
    @(negedge clk);
    check(sys_rst_req == 1'b0, "R9 pulse one cycle", {31'b0, sys_rst_req}, 32'h0);
    check(rsp_valid == 1'b0, "R10 idle no response", {31'b0, rsp_valid}, 32'h0);
    rd(12'h200, 32'h3, 1'b0, "R9 stored value");

    wr(12'h004, 32'h0000_767C, 1'b0, "R3 wrong lock key");
    rd(12'h00C, 32'h0, 1'b0, "R3 still open");
    wr(12'h004, 32'hFFFF_767B, 1'b0, "R3 lock");
    rd(12'h00C, 32'h1, 1'b0, "R3 locked");
    wr(12'h700, 32'h7, 1'b0, "R4 locked pinmux write");
    rd(12'h700, 32'h1601, 1'b0, "R4 pinmux kept");

    repeat (2) @(negedge clk);
    check(exp_d.size() == 0, "R10 all responses seen", exp_d.size(), 32'h0);
    finish_run();
  end
endmodule